// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit-Slot Engine

This block is the bit-level slave end of a single-wire, open-drain data bus. It samples the shared line through a synchroniser and times every low excursion against a microsecond tick derived from the system clock. A low pulse long enough to be a bus reset produces a one-cycle reset-seen strobe. Once the line is released again, the block answers with a presence pulse after a programmable delay. Shorter low pulses are time slots. Their meaning is fixed by a direction input that the command layer owns. In receive direction each slot is decoded into one bit at a fixed sampling point. In transmit direction the block asks the command layer for a bit and, for a zero, holds the line low past the point where the master samples.

Received bits leave as a valid-only stream (`rx_valid`, `rx_bit`). The bus cannot be stalled, so there is no ready: the consumer must take every bit in the cycle it is offered. Transmit bits arrive over a valid/ready handshake. `tx_ready` rises when a read slot opens and stays high until a transfer happens or the late limit passes. The command layer may hold `tx_valid` high ahead of time. A transfer happens in any cycle where both are high. There is no bus pull-up here. The line is a plain input plus an active-high pull-down request, which the surrounding logic turns into an open-drain driver.

Top module: `onewire_slave_slot`

## Requirements
- R1: After `rst_n` is released and before any line activity, `pull_low`, `rx_valid`, `tx_ready` and `rst_seen` are all 0.
- R2: A line low held without a break for RESET_MIN_US (default 480 µs) is a bus reset. `rst_seen` is high for exactly one cycle, RESET_MIN_US×CLKS_PER_US+2 clock edges after the first edge that samples the low level.
- R3: A low pulse shorter than RESET_MIN_US never raises `rst_seen`. It is treated as a time slot, and every falling edge outside presence handling restarts slot timing.
- R4: After a reset, once the line is seen high again, `pull_low` rises PRES_DELAY_US×CLKS_PER_US+2 edges after the first edge that samples the high level (default 30 µs). It stays high for exactly PRES_WIDTH_US×CLKS_PER_US cycles (default 120 µs).
- R5: In receive direction, SAMPLE_US×CLKS_PER_US+2 edges after the falling edge is first sampled (default 30 µs), `rx_valid` pulses for one cycle. `rx_bit` carries the synchronised line level at that point: high is 1, low is 0.
- R6: In transmit direction, `tx_ready` rises 2 edges after the falling edge is first sampled. It drops in the cycle after a transfer (`tx_ready` and `tx_valid` both high).
- R7: A transferred `tx_bit` of 0 asserts `pull_low` from the next cycle until READ_HOLD_US (default 45 µs) after the slot start. A transferred 1 leaves `pull_low` at 0.
- R8: If no transfer has happened by TX_LATE_US (default 10 µs) after the slot start, `tx_ready` falls and the slot returns a released (1) line. A `tx_valid` first presented in that final cycle still transfers.
- R9: The direction input is sampled only at a slot's falling edge. Changing `mode_tx` mid-slot neither cancels that slot's receive sample nor opens a transmit request.
- R10: From reset detection until the presence pulse ends, falling edges start no slot. This covers master glitches and the block's own pull-down: there is no `rx_valid`, no `tx_ready`, and presence timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Level of the shared bus line (asynchronous) |
| mode_tx | input | 1 | Slot direction: 0 receive (master writes), 1 transmit (master reads) |
| pull_low | output | 1 | Request to pull the bus line low |
| rx_valid | output | 1 | One-cycle strobe: a received bit is offered |
| rx_bit | output | 1 | Received bit value, valid with `rx_valid` |
| tx_ready | output | 1 | Block is waiting for the bit to return in the current read slot |
| tx_valid | input | 1 | Command layer offers a transmit bit |
| tx_bit | input | 1 | Transmit bit value |
| rst_seen | output | 1 | One-cycle strobe: a bus reset was recognised |

## Verification
Two functions can meet in one cycle: the transmit handshake, and the late limit that closes it. The bench counts edges from the master's falling edge and raises `tx_valid` for the first time exactly in the cycle where the limit expires. It expects the transfer to win, so the line reads 0 at the master's sample point. One cycle later, the same stimulus must lose and read 1. A second overlap puts a master glitch inside the presence delay. It is judged by presence timing that matches a clean reset to the cycle, and by no receive strobe.

// File: rtl/ow_slot_pkg.sv
package ow_slot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_RST_LOW,
    ST_PRES_WAIT,
    ST_PRES_DRIVE
  } ow_state_t;

  function automatic int ow_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_lvl,
  output logic fall,
  output logic rise
);

  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-1:0], line_in};
  end

  assign line_lvl = chain_q[STAGES-1];
  assign fall     = chain_q[STAGES] & ~chain_q[STAGES-1];
  assign rise     = ~chain_q[STAGES] & chain_q[STAGES-1];

endmodule

// File: rtl/ow_us_timer.sv
module ow_us_timer #(
  parameter int CLKS_PER_US = 100,
  parameter int US_W        = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  output logic            tick,
  output logic [US_W-1:0] us_cnt
);

  localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);
  localparam logic [US_W-1:0]  US_TOP   = '1;

  logic [PRE_W-1:0] pre_q;

  assign tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      us_cnt <= '0;
    end else if (restart) begin
      pre_q  <= '0;
      us_cnt <= '0;
    end else if (tick) begin
      pre_q <= '0;
      if (us_cnt != US_TOP) us_cnt <= us_cnt + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/ow_slot_ctrl.sv
module ow_slot_ctrl
  import ow_slot_pkg::*;
#(
  parameter int US_W          = 9,
  parameter int SAMPLE_US     = 30,
  parameter int RESET_MIN_US  = 480,
  parameter int PRES_DELAY_US = 30,
  parameter int PRES_WIDTH_US = 120,
  parameter int TX_LATE_US    = 10,
  parameter int READ_HOLD_US  = 45
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [US_W-1:0] us_cnt,
  input  logic            line_lvl,
  input  logic            fall,
  input  logic            rise,
  input  logic            mode_tx,
  input  logic            tx_valid,
  input  logic            tx_bit,
  output logic            restart,
  output logic            pull_low,
  output logic            rx_valid,
  output logic            rx_bit,
  output logic            tx_ready,
  output logic            rst_seen
);

  ow_state_t st_q, st_d;
  logic      slot_tx_q;
  logic      low_run_q;

  logic hit_samp, hit_rst, hit_pd, hit_pw, hit_late, hit_hold;
  logic edge_open, long_low, handshake;

  assign hit_samp = tick && (us_cnt == US_W'(SAMPLE_US - 1));
  assign hit_rst  = tick && (us_cnt == US_W'(RESET_MIN_US - 1));
  assign hit_pd   = tick && (us_cnt == US_W'(PRES_DELAY_US - 1));
  assign hit_pw   = tick && (us_cnt == US_W'(PRES_WIDTH_US - 1));
  assign hit_late = tick && (us_cnt == US_W'(TX_LATE_US - 1));
  assign hit_hold = tick && (us_cnt == US_W'(READ_HOLD_US - 1));

  // Slots open only outside reset / presence handling
  assign edge_open = ((st_q == ST_IDLE) || (st_q == ST_SLOT)) && fall;
  assign long_low  = (st_q == ST_SLOT) && low_run_q && !rise && hit_rst;
  assign handshake = tx_ready && tx_valid;

  assign restart = edge_open
                || ((st_q == ST_RST_LOW) && rise)
                || ((st_q == ST_PRES_WAIT) && hit_pd);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE, ST_SLOT: begin
        if (edge_open)     st_d = ST_SLOT;
        else if (long_low) st_d = ST_RST_LOW;
      end
      ST_RST_LOW:    if (rise)   st_d = ST_PRES_WAIT;
      ST_PRES_WAIT:  if (hit_pd) st_d = ST_PRES_DRIVE;
      ST_PRES_DRIVE: if (hit_pw) st_d = ST_IDLE;
      default:                   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      slot_tx_q <= 1'b0;
      low_run_q <= 1'b0;
      pull_low  <= 1'b0;
      rx_valid  <= 1'b0;
      rx_bit    <= 1'b0;
      tx_ready  <= 1'b0;
      rst_seen  <= 1'b0;
    end else begin
      st_q     <= st_d;
      rx_valid <= 1'b0;
      rst_seen <= 1'b0;
      if (edge_open) begin
        slot_tx_q <= mode_tx;
        low_run_q <= 1'b1;
        tx_ready  <= mode_tx;
      end else if (st_q == ST_SLOT) begin
        if (rise) low_run_q <= 1'b0;
        if (long_low) begin
          rst_seen  <= 1'b1;
          tx_ready  <= 1'b0;
          pull_low  <= 1'b0;
          low_run_q <= 1'b0;
        end else begin
          if (handshake) begin
            tx_ready <= 1'b0;
            if (!tx_bit) pull_low <= 1'b1;
          end else if (hit_late) begin
            tx_ready <= 1'b0;
          end
          if (hit_hold) pull_low <= 1'b0;
          if (!slot_tx_q && hit_samp) begin
            rx_valid <= 1'b1;
            rx_bit   <= line_lvl;
          end
        end
      end else if ((st_q == ST_PRES_WAIT) && hit_pd) begin
        pull_low <= 1'b1;
      end else if ((st_q == ST_PRES_DRIVE) && hit_pw) begin
        pull_low <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/onewire_slave_slot.sv
module onewire_slave_slot
  import ow_slot_pkg::*;
#(
  parameter int CLKS_PER_US   = 100,
  parameter int SYNC_STAGES   = 2,
  parameter int SAMPLE_US     = 30,
  parameter int RESET_MIN_US  = 480,
  parameter int PRES_DELAY_US = 30,
  parameter int PRES_WIDTH_US = 120,
  parameter int TX_LATE_US    = 10,
  parameter int READ_HOLD_US  = 45
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic mode_tx,
  output logic pull_low,
  output logic rx_valid,
  output logic rx_bit,
  output logic tx_ready,
  input  logic tx_valid,
  input  logic tx_bit,
  output logic rst_seen
);

  localparam int MAX_US = ow_max(ow_max(ow_max(SAMPLE_US, RESET_MIN_US),
                                        ow_max(PRES_DELAY_US, PRES_WIDTH_US)),
                                 ow_max(TX_LATE_US, READ_HOLD_US));
  localparam int US_W   = $clog2(MAX_US + 1);

  logic            line_lvl, fall, rise;
  logic            tick, restart;
  logic [US_W-1:0] us_cnt;

  ow_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (line_in),
    .line_lvl (line_lvl),
    .fall     (fall),
    .rise     (rise)
  );

  ow_us_timer #(.CLKS_PER_US(CLKS_PER_US), .US_W(US_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .tick    (tick),
    .us_cnt  (us_cnt)
  );

  ow_slot_ctrl #(
    .US_W          (US_W),
    .SAMPLE_US     (SAMPLE_US),
    .RESET_MIN_US  (RESET_MIN_US),
    .PRES_DELAY_US (PRES_DELAY_US),
    .PRES_WIDTH_US (PRES_WIDTH_US),
    .TX_LATE_US    (TX_LATE_US),
    .READ_HOLD_US  (READ_HOLD_US)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .us_cnt   (us_cnt),
    .line_lvl (line_lvl),
    .fall     (fall),
    .rise     (rise),
    .mode_tx  (mode_tx),
    .tx_valid (tx_valid),
    .tx_bit   (tx_bit),
    .restart  (restart),
    .pull_low (pull_low),
    .rx_valid (rx_valid),
    .rx_bit   (rx_bit),
    .tx_ready (tx_ready),
    .rst_seen (rst_seen)
  );

endmodule

// File: rtl/ow_slot_checker.sv
module ow_slot_checker (
  input logic clk,
  input logic rst_n,
  input logic pull_low,
  input logic rx_valid,
  input logic tx_ready,
  input logic tx_valid,
  input logic tx_bit,
  input logic rst_seen
);

  AST_RST_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_seen |=> !rst_seen); // R2

  AST_RX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R5

  AST_ONE_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && tx_valid) |=> !tx_ready); // R6

  AST_ZERO_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && tx_valid && !tx_bit) |=> pull_low); // R7

  AST_ONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && tx_valid && tx_bit) |=> !pull_low); // R7

  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && tx_ready)); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_seen |-> (!tx_ready && !pull_low)); // R10

endmodule

bind onewire_slave_slot ow_slot_checker u_ow_slot_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .pull_low (pull_low),
  .rx_valid (rx_valid),
  .tx_ready (tx_ready),
  .tx_valid (tx_valid),
  .tx_bit   (tx_bit),
  .rst_seen (rst_seen)
);

// File: tb/onewire_slave_slot_bench.sv
`timescale 1ns/1ps
module onewire_slave_slot_bench;

  localparam int CPU  = 4;
  localparam int SAMP = 30, RST = 480, PD = 30, PW = 120, TXL = 10, HOLD = 45;

  logic clk = 1'b0, rst_n = 1'b0;
  logic master_low = 1'b0, mode_tx = 1'b0, tx_valid = 1'b0, tx_bit = 1'b0;
  logic pull_low, rx_valid, rx_bit, tx_ready, rst_seen;
  wire  bus = ~(master_low | pull_low);

  always #5 clk = ~clk;

  onewire_slave_slot #(.CLKS_PER_US(CPU)) u_onewire_slave_slot (
    .clk(clk), .rst_n(rst_n), .line_in(bus), .mode_tx(mode_tx),
    .pull_low(pull_low), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_bit(tx_bit),
    .rst_seen(rst_seen)
  );

  int n_cmp = 0, n_bad = 0, cyc_n = 0;
  bit done = 0;

  // ---------------- behavioural reference ----------------
  int mst, cyc;
  bit h1, h2, h3, mtx, lowrun, f_m, r_m, lr_m;
  bit e_pull, e_rxv, e_rxb, e_rdy, e_rst;

  always @(posedge clk) cyc_n <= cyc_n + 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 = 1; h2 = 1; h3 = 1; mst = 0; cyc = 0; mtx = 0; lowrun = 0;
      e_pull = 0; e_rxv = 0; e_rxb = 0; e_rdy = 0; e_rst = 0;
    end else begin
      f_m = h3 && !h2; r_m = !h3 && h2; lr_m = lowrun;
      e_rxv = 0; e_rst = 0; cyc = cyc + 1;
      if ((mst == 0 || mst == 1) && f_m) begin
        mst = 1; cyc = 0; mtx = mode_tx; lowrun = 1; e_rdy = mode_tx;
      end else if (mst == 1) begin
        if (r_m) lowrun = 0;
        if (lr_m && !r_m && cyc == RST*CPU) begin
          e_rst = 1; e_rdy = 0; e_pull = 0; lowrun = 0; mst = 2;
        end else begin
          if (e_rdy && tx_valid) begin
            e_rdy = 0;
            if (!tx_bit) e_pull = 1;
          end else if (cyc == TXL*CPU) e_rdy = 0;
          if (cyc == HOLD*CPU) e_pull = 0;
          if (!mtx && cyc == SAMP*CPU) begin e_rxv = 1; e_rxb = h2; end
        end
      end else if (mst == 2) begin
        if (r_m) begin mst = 3; cyc = 0; end
      end else if (mst == 3) begin
        if (cyc == PD*CPU) begin mst = 4; cyc = 0; e_pull = 1; end
      end else if (mst == 4) begin
        if (cyc == PW*CPU) begin mst = 0; e_pull = 0; end
      end
      h3 = h2; h2 = h1; h1 = bus;
    end
  end

  // ---------------- per-cycle comparison and monitors ----------------
  bit rx_q[$];
  int rst_cnt = 0, rst_cyc = 0, rdy_cnt = 0, pres_rise = 0, pres_fall = 0;
  bit prev_pull = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (rx_valid !== e_rxv || (e_rxv && rx_bit !== e_rxb)) begin
        n_bad++;
        $display("FAIL R5 cyc %0d rx_valid/bit %b%b expected %b%b", cyc_n, rx_valid, rx_bit, e_rxv, e_rxb);
      end
      if (tx_ready !== e_rdy) begin
        n_bad++;
        $display("FAIL R6 cyc %0d tx_ready %b expected %b", cyc_n, tx_ready, e_rdy);
      end
      if (pull_low !== e_pull) begin
        n_bad++;
        $display("FAIL R7 cyc %0d pull_low %b expected %b", cyc_n, pull_low, e_pull);
      end
      if (rst_seen !== e_rst) begin
        n_bad++;
        $display("FAIL R2 cyc %0d rst_seen %b expected %b", cyc_n, rst_seen, e_rst);
      end
      if (rx_valid) rx_q.push_back(rx_bit);
      if (rst_seen) begin rst_cnt++; rst_cyc = cyc_n; end
      if (tx_ready) rdy_cnt++;
      if (pull_low && !prev_pull) pres_rise = cyc_n;
      if (!pull_low && prev_pull) pres_fall = cyc_n;
      prev_pull = pull_low;
    end
  end

  task automatic check(string tag, bit ok, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_us(int n);
    repeat (n*CPU) @(negedge clk);
  endtask

  task automatic write_slot(bit b);
    master_low = 1; wait_us(b ? 1 : 62);
    master_low = 0; wait_us(b ? 64 : 3);
  endtask

  task automatic read_slot(bit give, bit b, output bit got);
    tx_valid = give; tx_bit = b;
    master_low = 1; wait_us(1);
    master_low = 0; wait_us(13);
    got = bus;
    wait_us(51);
    tx_valid = 0;
  endtask

  task automatic bus_reset(bit glitch);
    int k, k2;
    k = cyc_n; master_low = 1; wait_us(500);
    k2 = cyc_n; master_low = 0;
    if (glitch) begin
      wait_us(10); master_low = 1; wait_us(2); master_low = 0; wait_us(158);
    end else wait_us(170);
    check("R2 reset strobe latency", rst_cyc - k == RST*CPU + 3, rst_cyc - k, RST*CPU + 3);
    check("R4 presence delay", pres_rise - k2 == PD*CPU + 3, pres_rise - k2, PD*CPU + 3);
    check("R4 presence width", pres_fall - pres_rise == PW*CPU, pres_fall - pres_rise, PW*CPU);
  endtask

  initial begin
    bit got;
    int rc, k, nrx, nrdy;
    bit exp_bits[5] = '{1, 0, 1, 1, 0};
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset state", {pull_low, rx_valid, tx_ready, rst_seen} == 4'b0,
          {pull_low, rx_valid, tx_ready, rst_seen}, 0);

    // bus reset in receive direction
    nrx = rx_q.size();
    bus_reset(0);
    check("R2 one strobe", rst_cnt == 1, rst_cnt, 1);
    check("R10 no rx from reset/presence", rx_q.size() == nrx + 1, rx_q.size(), nrx + 1);
    rx_q.delete();

    // write slots
    foreach (exp_bits[i]) write_slot(exp_bits[i]);
    check("R5 bit count", rx_q.size() == 5, rx_q.size(), 5);
    foreach (exp_bits[i])
      if (i < rx_q.size()) check("R5 bit value", rx_q[i] == exp_bits[i], rx_q[i], exp_bits[i]);
    rx_q.delete();

    // short long-ish low: a slot, not a reset
    rc = rst_cnt;
    master_low = 1; wait_us(400); master_low = 0; wait_us(20);
    check("R3 no reset for 400us low", rst_cnt == rc, rst_cnt, rc);
    check("R3 decoded as slot bit 0", rx_q.size() == 1 && rx_q[0] == 0, rx_q.size(), 1);
    rx_q.delete();

    // mode flips mid-slot: receive slot stays receive
    nrdy = rdy_cnt;
    master_low = 1; wait_us(2); mode_tx = 1; wait_us(60); master_low = 0; wait_us(3);
    check("R9 rx kept after mode flip", rx_q.size() == 1, rx_q.size(), 1);
    check("R9 no tx_ready", rdy_cnt == nrdy, rdy_cnt, nrdy);
    rx_q.delete();

    // read slots; mode_tx is 1 now
    read_slot(1, 0, got); check("R7 return 0", got == 0, got, 0);
    read_slot(1, 1, got); check("R7 return 1", got == 1, got, 1);
    read_slot(1, 0, got); check("R7 return 0 again", got == 0, got, 0);
    check("R9 no rx in transmit", rx_q.size() == 0, rx_q.size(), 0);

    // missed handshake + ready timing
    tx_valid = 0; k = cyc_n; master_low = 1;
    repeat (2) @(negedge clk);
    check("R6 ready not yet", tx_ready == 0, tx_ready, 0);
    @(negedge clk);
    check("R6 ready up", tx_ready == 1, tx_ready, 1);
    @(negedge clk); master_low = 0; wait_us(13);
    check("R8 missed slot reads 1", bus == 1, bus, 1);
    check("R8 ready closed", tx_ready == 0, tx_ready, 0);
    wait_us(51);

    // handshake in the final cycle of the window: transfer wins
    k = cyc_n; master_low = 1;
    repeat (4) @(negedge clk); master_low = 0;
    repeat (TXL*CPU - 2) @(negedge clk);
    check("R8 ready in last cycle", tx_ready == 1, tx_ready, 1);
    tx_valid = 1; tx_bit = 0;
    repeat (14*CPU - (TXL*CPU + 2)) @(negedge clk);
    check("R8 last-cycle transfer reads 0", bus == 0, bus, 0);
    wait_us(51); tx_valid = 0;

    // one cycle too late: no transfer
    master_low = 1;
    repeat (4) @(negedge clk); master_low = 0;
    repeat (TXL*CPU - 1) @(negedge clk);
    tx_valid = 1; tx_bit = 0;
    repeat (14*CPU - (TXL*CPU + 3)) @(negedge clk);
    check("R8 late offer reads 1", bus == 1, bus, 1);
    wait_us(51); tx_valid = 0;

    // reset in transmit direction with a glitch during presence delay
    nrdy = rdy_cnt; rst_cnt = 0; nrx = rx_q.size();
    bus_reset(1);
    check("R10 only the opening slot raised ready", rdy_cnt - nrdy <= TXL*CPU, rdy_cnt - nrdy, TXL*CPU);
    check("R10 glitch gave no rx", rx_q.size() == nrx, rx_q.size(), nrx);
    check("R2 strobe in transmit direction", rst_cnt == 1, rst_cnt, 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule